// File: doc/BRIEF.md
# Packed Integer Media ALU

A single-stage datapath that executes one packed integer media operation per cycle on two operands cut into byte or 16-bit word lanes. An opcode picks one of eight functions: lane-wise unsigned byte max or min, lane-wise signed word max or min, a byte sign-bit gather, an unsigned word multiply keeping the upper product half, a horizontal sum of absolute byte differences, and a word permutation steered by an 8-bit immediate.

Operands, opcode and immediate are sampled together on a cycle where `valid_i` is high. The result is registered and presented one cycle later with `valid_o`. Opcodes outside the defined set produce a zero result and raise `illegal_o`. The operand width is the parameter `DATA_W`, 64 by default. At 128 the byte mask grows to one bit per byte lane and the shuffle acts on each 64-bit half with the same immediate.

Top module: `simd_media_alu`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `illegal_o` and `result_o` are all zero.
- R2: `valid_o` is high exactly one cycle after a cycle with `valid_i` high. A cycle with `valid_i` low leaves `result_o` unchanged in the next cycle.
- R3: Opcode 0 returns the larger unsigned value of each byte lane pair. Opcode 1 returns the smaller.
- R4: Opcode 2 returns the larger two's-complement value of each 16-bit lane pair. Opcode 3 returns the smaller.
- R5: Opcode 4 sets result bit i to bit 7 of byte lane i of operand A. Every bit above the mask is zero.
- R6: Opcode 5 puts bits 31:16 of the unsigned 32-bit product of each word lane pair into that lane.
- R7: Opcode 6 puts the sum of |A byte − B byte| over all byte lanes into result bits 15:0. Bits above 15 are zero, and the sum never exceeds 255 times the lane count.
- R8: Opcode 7 makes destination word i equal to word imm[2i+1:2i] of operand A. One source word may feed several destinations.
- R9: Opcodes 8 to 15 give a zero result with `illegal_o` high alongside `valid_o`. `illegal_o` is low for opcodes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation request strobe |
| op_i | input | 4 | Operation code |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B |
| imm_i | input | 8 | Shuffle immediate |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Undefined opcode flag |
| result_o | output | DATA_W | Registered result |

## Verification
Every operation has a latency of one cycle. A request driven on a falling edge is captured at the next rising edge, and its result is checked at the falling edge after that. The driver queues the expected result and flag when it issues the request. The monitor pops one entry for each cycle in which `valid_o` is high. In cycles without a result, the monitor checks that `result_o` still holds its last value. Because of this, gaps and back-to-back requests are both checked against the same one-cycle timing.

// File: rtl/simd_media_alu_pkg.sv
package simd_media_alu_pkg;
  typedef enum logic [3:0] {
    OP_UMAXB  = 4'd0,
    OP_UMINB  = 4'd1,
    OP_SMAXW  = 4'd2,
    OP_SMINW  = 4'd3,
    OP_MSKB   = 4'd4,
    OP_MULHUW = 4'd5,
    OP_SADB   = 4'd6,
    OP_SHUFW  = 4'd7
  } media_op_e;

  localparam int unsigned SAD_W = 16;
endpackage

// File: rtl/simd_lane_minmax.sv
module simd_lane_minmax #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned LANE_W    = 8,
  parameter bit          IS_SIGNED = 1'b0
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sel_max_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned N_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    logic              a_gt;
    assign la = a_i[l*LANE_W +: LANE_W];
    assign lb = b_i[l*LANE_W +: LANE_W];
    if (IS_SIGNED) begin : g_s
      assign a_gt = $signed(la) > $signed(lb);
    end else begin : g_u
      assign a_gt = la > lb;
    end
    assign y_o[l*LANE_W +: LANE_W] = (a_gt == sel_max_i) ? la : lb;
  end
endmodule

// File: rtl/simd_mulhi.sv
module simd_mulhi #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned N_W = DATA_W / 16;

  for (genvar w = 0; w < N_W; w++) begin : g_word
    logic [31:0] prod;
    assign prod = 32'(a_i[w*16 +: 16]) * 32'(b_i[w*16 +: 16]);
    assign y_o[w*16 +: 16] = prod[31:16];
  end
endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]                     a_i,
  input  logic [DATA_W-1:0]                     b_i,
  output logic [simd_media_alu_pkg::SAD_W-1:0]  sum_o
);
  import simd_media_alu_pkg::*;
  localparam int unsigned N_B = DATA_W / 8;

  logic [N_B-1:0][7:0] diff;

  for (genvar i = 0; i < N_B; i++) begin : g_diff
    logic [7:0] ab, bb;
    assign ab = a_i[i*8 +: 8];
    assign bb = b_i[i*8 +: 8];
    assign diff[i] = (ab > bb) ? (ab - bb) : (bb - ab);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N_B; i++) sum_o = sum_o + SAD_W'(diff[i]);
  end
endmodule

// File: rtl/simd_shuffle.sv
module simd_shuffle #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [7:0]        imm_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned N_GRP = DATA_W / 64;

  // Each 64-bit group is permuted independently with the same immediate
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [3:0][15:0] src;
    assign src = a_i[g*64 +: 64];
    for (genvar d = 0; d < 4; d++) begin : g_dst
      assign y_o[g*64 + d*16 +: 16] = src[imm_i[2*d +: 2]];
    end
  end
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
  import simd_media_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [7:0]        imm_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned N_B     = DATA_W / 8;
  localparam int unsigned SAD_MAX = N_B * 255;

  logic [DATA_W-1:0] ub_y, sw_y, mul_y, shuf_y, res_d;
  logic [SAD_W-1:0]  sad_sum;
  logic [N_B-1:0]    mask;
  logic              ill_d, ill_q;
  logic [3:0]        op_q;

  simd_lane_minmax #(.DATA_W(DATA_W), .LANE_W(8), .IS_SIGNED(1'b0)) u_ub (
    .a_i(a_i), .b_i(b_i), .sel_max_i(op_i == OP_UMAXB), .y_o(ub_y)
  );

  simd_lane_minmax #(.DATA_W(DATA_W), .LANE_W(16), .IS_SIGNED(1'b1)) u_sw (
    .a_i(a_i), .b_i(b_i), .sel_max_i(op_i == OP_SMAXW), .y_o(sw_y)
  );

  simd_mulhi #(.DATA_W(DATA_W)) u_mul (.a_i(a_i), .b_i(b_i), .y_o(mul_y));

  simd_sad #(.DATA_W(DATA_W)) u_sad (.a_i(a_i), .b_i(b_i), .sum_o(sad_sum));

  simd_shuffle #(.DATA_W(DATA_W)) u_shuf (.a_i(a_i), .imm_i(imm_i), .y_o(shuf_y));

  for (genvar i = 0; i < N_B; i++) begin : g_mask
    assign mask[i] = a_i[i*8 + 7];
  end

  always_comb begin
    res_d = '0;
    ill_d = 1'b0;
    case (op_i)
      OP_UMAXB, OP_UMINB: res_d = ub_y;
      OP_SMAXW, OP_SMINW: res_d = sw_y;
      OP_MSKB:            res_d = DATA_W'(mask);
      OP_MULHUW:          res_d = mul_y;
      OP_SADB:            res_d = DATA_W'(sad_sum);
      OP_SHUFW:           res_d = shuf_y;
      default:            ill_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      ill_q    <= 1'b0;
      op_q     <= '0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ill_q    <= ill_d;
        op_q     <= op_i;
        result_o <= res_d;
      end
    end
  end

  assign illegal_o = ill_q & valid_o;

  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_mask_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_MSKB) |=> result_o[DATA_W-1:N_B] == '0);
  assert_sad_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SADB) |=> result_o[DATA_W-1:SAD_W] == '0);
  assert_sad_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_q == OP_SADB) |-> result_o[SAD_W-1:0] <= SAD_W'(SAD_MAX));
  assert_illegal_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == '0);
  assert_illegal_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[3]) |=> illegal_o);
endmodule

// File: tb/simd_media_alu_tb.sv
module simd_media_alu_tb;
  localparam int unsigned DW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [3:0]    op_i = '0;
  logic [DW-1:0] a_i = '0, b_i = '0;
  logic [7:0]    imm_i = '0;
  logic          valid_o, illegal_o;
  logic [DW-1:0] result_o;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          ill;
    logic [3:0]    op;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  logic [DW-1:0] last_res = '0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  simd_media_alu #(.DATA_W(DW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [DW-1:0] a, logic [DW-1:0] b,
                                 logic [7:0] imm);
    exp_t e;
    int s;
    e.res = '0; e.ill = 1'b0; e.op = op;
    case (op)
      4'd0, 4'd1: for (int i = 0; i < 8; i++) begin
        int x, y;
        x = a[i*8 +: 8]; y = b[i*8 +: 8];
        e.res[i*8 +: 8] = 8'((op == 0) ? ((x > y) ? x : y) : ((x < y) ? x : y));
      end
      4'd2, 4'd3: for (int i = 0; i < 4; i++) begin
        int x, y;
        x = 32'($signed(a[i*16 +: 16])); y = 32'($signed(b[i*16 +: 16]));
        e.res[i*16 +: 16] = 16'((op == 2) ? ((x > y) ? x : y) : ((x < y) ? x : y));
      end
      4'd4: for (int i = 0; i < 8; i++) e.res[i] = a[i*8 + 7];
      4'd5: for (int i = 0; i < 4; i++) begin
        longint p;
        p = longint'(a[i*16 +: 16]) * longint'(b[i*16 +: 16]);
        e.res[i*16 +: 16] = 16'(p >> 16);
      end
      4'd6: begin
        s = 0;
        for (int i = 0; i < 8; i++) begin
          int d;
          d = int'(a[i*8 +: 8]) - int'(b[i*8 +: 8]);
          s += (d < 0) ? -d : d;
        end
        e.res[15:0] = 16'(s);
      end
      4'd7: for (int i = 0; i < 4; i++) begin
        int sel;
        sel = int'(imm[2*i +: 2]);
        e.res[i*16 +: 16] = a[sel*16 +: 16];
      end
      default: e.ill = 1'b1;
    endcase
    return e;
  endfunction

  task automatic issue(logic [3:0] op, logic [DW-1:0] a, logic [DW-1:0] b, logic [7:0] imm);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; imm_i = imm;
    exp_q.push_back(model(op, a, b, imm));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      op_i = 4'($urandom); a_i = {$urandom, $urandom}; b_i = {$urandom, $urandom};
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (valid_o) begin
          exp_t e;
          checks++;
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R2 unexpected valid_o: actual=1 expected=0");
          end else begin
            e = exp_q.pop_front();
            if (result_o !== e.res || illegal_o !== e.ill) begin
              failures++;
              $display("FAIL %s op=%0d: actual res=%h ill=%b expected res=%h ill=%b",
                       req_of(e.op), e.op, result_o, illegal_o, e.res, e.ill);
            end
          end
          last_res = result_o;
        end else begin
          checks++;
          if (result_o !== last_res || illegal_o !== 1'b0 || exp_q.size() > 1) begin
            failures++;
            $display("FAIL R2 hold: actual res=%h ill=%b expected res=%h ill=0",
                     result_o, illegal_o, last_res);
          end
        end
      end
    end
  end

  initial begin
    #200_000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (valid_o !== 1'b0 || illegal_o !== 1'b0 || result_o !== '0) begin
      failures++;
      $display("FAIL R1 reset: actual v=%b ill=%b res=%h expected 0 0 0",
               valid_o, illegal_o, result_o);
    end
    rst_ni = 1'b1;
    idle(2);
    // R3 unsigned byte max/min
    issue(4'd0, 64'h00FF_7F80_1234_0102, 64'h0100_807F_3412_0102, 8'h00);
    issue(4'd1, 64'h00FF_7F80_1234_0102, 64'h0100_807F_3412_0102, 8'h00);
    // R4 signed word max/min, negative vs positive, equal, extremes
    issue(4'd2, 64'h8000_FFFF_7FFF_1234, 64'h7FFF_0001_8000_1234, 8'h00);
    issue(4'd3, 64'h8000_FFFF_7FFF_1234, 64'h7FFF_0001_8000_1234, 8'h00);
    idle(1);
    // R5 mask
    issue(4'd4, 64'h80_7F_FF_00_81_01_C0_40, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    issue(4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h00);
    // R6 high multiply
    issue(4'd5, 64'hFFFF_8000_0001_1234, 64'hFFFF_8000_FFFF_5678, 8'h00);
    // R7 SAD, maximum and mixed
    issue(4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h00);
    issue(4'd6, 64'h0010_2030_4050_6070, 64'h7060_5040_3020_1000, 8'h00);
    idle(2);
    // R8 shuffle: reverse, broadcast, identity
    issue(4'd7, 64'h4444_3333_2222_1111, 64'h0, 8'h1B);
    issue(4'd7, 64'h4444_3333_2222_1111, 64'h0, 8'hAA);
    issue(4'd7, 64'h4444_3333_2222_1111, 64'h0, 8'hE4);
    // R9 illegal opcodes
    issue(4'd8, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1, 8'hFF);
    issue(4'd15, 64'h1, 64'h2, 8'h00);
    issue(4'd0, 64'h1, 64'h2, 8'h00);
    idle(3);
    // Random sweep
    for (int k = 0; k < 200; k++) begin
      issue(4'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom));
      if (k % 7 == 0) idle(1);
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 missing results: actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule